// File: doc/BRIEF.md
# Configurable Bit-Stream Line Coder

This block prepares a serial bit stream for a modulator and restores it on the receive side. On the transmit side it takes one data bit per input strobe and passes it through up to four transforms, each switched on by its own bit of a 4-bit control register: complementing, whitening with a self-synchronizing scrambler, differential (transition) coding, and Manchester coding. The result leaves as a serial chip stream with its own strobe. With Manchester off there is one chip per bit; with Manchester on there are two chips per bit, on consecutive cycles.

The receive half takes a chip stream with its strobe and undoes the same transforms in the reverse order, using the same control register. It returns one data bit per decoded symbol and raises an error pulse when a Manchester symbol carries two equal halves. The scrambler adds no bits, so whitening does not change the bit rate, and the descrambler locks onto any stream after one register length of received bits.

Top module: `line_codec`

## Requirements
- R1: After reset the control register holds 4'b0010 (only differential coding on), both output strobes and the error flag are low; a cycle with cfg_we high loads cfg_wdata into the control register, used from the next cycle on.
- R2: With control bit 0 set, every data bit is complemented before the other transmit transforms.
- R3: With control bit 1 set, the coder keeps a level that resets to 0; a 1 toggles the level and a 0 keeps it, and the chip sent is the new level.
- R4: With control bit 2 set, the scrambled bit is the bit XOR the scrambled bits from 12 and 17 bits before; this history records the value at that stage for every accepted bit, enabled or not, and is all zero after reset.
- R5: With control bit 3 set, a stage value of 1 is sent as chips 1 then 0 and a 0 as chips 0 then 1, on the two cycles after the bit is accepted; a new bit may only be offered once the second chip is out.
- R6: With control bit 3 clear, each accepted bit gives exactly one chip, valid in the cycle after acceptance, and bits may be offered on every cycle.
- R7: The transmit order is complement, then scramble, then differential coding, then Manchester.
- R8: The receive side inverts the transmit chain in reverse order, so a loop of tx_chip into rx_chip returns every data bit unchanged under any control value; rx_bit_valid rises in the cycle after the last chip of a symbol.
- R9: With control bit 3 set, a received chip pair with equal halves sets rx_man_err together with rx_bit_valid for that symbol; a pair with differing halves leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load control register |
| cfg_wdata | input | 4 | Control value: bit0 complement, bit1 differential, bit2 scramble, bit3 Manchester |
| tx_bit | input | 1 | Transmit data bit |
| tx_valid | input | 1 | Transmit bit strobe |
| tx_chip | output | 1 | Coded chip |
| tx_chip_valid | output | 1 | Chip strobe |
| rx_chip | input | 1 | Received chip |
| rx_chip_valid | input | 1 | Received chip strobe |
| rx_bit | output | 1 | Decoded data bit |
| rx_bit_valid | output | 1 | Decoded bit strobe |
| rx_man_err | output | 1 | Manchester symbol had equal halves |

## Verification
The assertions watch on every cycle the strobe timing: one-cycle latency from accepted bit to chip and from final chip to decoded bit, the complemented second Manchester chip, the spacing rule for transmit bits, the error flag appearing only with a decoded Manchester bit, and control loading. Only the bench's scenarios can show the bit values: the inversion, the differential level, the scrambler taps on periodic data, the transform order, and the round trip through the decoder under every control setting, which a per-cycle reference model with its own queues checks.

// File: rtl/line_codec.sv
module line_codec #(
  parameter int        SCR_LEN  = 17,
  parameter int        SCR_TAP  = 12,
  parameter logic [3:0] CTRL_RST = 4'b0010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [3:0] cfg_wdata,
  input  logic       tx_bit,
  input  logic       tx_valid,
  output logic       tx_chip,
  output logic       tx_chip_valid,
  input  logic       rx_chip,
  input  logic       rx_chip_valid,
  output logic       rx_bit,
  output logic       rx_bit_valid,
  output logic       rx_man_err
);

  logic [3:0] ctrl;
  logic inv_en, dif_en, scr_en, man_en;
  assign inv_en = ctrl[0];
  assign dif_en = ctrl[1];
  assign scr_en = ctrl[2];
  assign man_en = ctrl[3];

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl <= CTRL_RST;
    else if (cfg_we) ctrl <= cfg_wdata;
  end

  // transmit chain
  logic [SCR_LEN-1:0] tx_hist;
  logic tx_lvl, tx_pend;
  logic tx_s1, tx_s2, tx_s3;

  assign tx_s1 = tx_bit ^ inv_en;
  assign tx_s2 = scr_en ? (tx_s1 ^ tx_hist[SCR_TAP-1] ^ tx_hist[SCR_LEN-1]) : tx_s1;
  assign tx_s3 = dif_en ? (tx_lvl ^ tx_s2) : tx_s2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_hist       <= '0;
      tx_lvl        <= 1'b0;
      tx_pend       <= 1'b0;
      tx_chip       <= 1'b0;
      tx_chip_valid <= 1'b0;
    end else if (tx_valid) begin
      tx_hist       <= {tx_hist[SCR_LEN-2:0], tx_s2};
      if (dif_en) tx_lvl <= tx_s3;
      tx_chip       <= tx_s3;
      tx_chip_valid <= 1'b1;
      tx_pend       <= man_en;
    end else if (tx_pend) begin
      tx_chip       <= ~tx_chip;
      tx_chip_valid <= 1'b1;
      tx_pend       <= 1'b0;
    end else begin
      tx_chip_valid <= 1'b0;
    end
  end

  // receive chain
  logic [SCR_LEN-1:0] rx_hist;
  logic rx_prev, rx_half, rx_first;
  logic rx_c, rx_d, rx_b;
  logic rx_last;

  assign rx_last = !man_en || rx_half;
  assign rx_c = man_en ? rx_first : rx_chip;
  assign rx_d = dif_en ? (rx_c ^ rx_prev) : rx_c;
  assign rx_b = (scr_en ? (rx_d ^ rx_hist[SCR_TAP-1] ^ rx_hist[SCR_LEN-1]) : rx_d) ^ inv_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_hist      <= '0;
      rx_prev      <= 1'b0;
      rx_half      <= 1'b0;
      rx_first     <= 1'b0;
      rx_bit       <= 1'b0;
      rx_bit_valid <= 1'b0;
      rx_man_err   <= 1'b0;
    end else if (rx_chip_valid && !rx_last) begin
      rx_first     <= rx_chip;
      rx_half      <= 1'b1;
      rx_bit_valid <= 1'b0;
      rx_man_err   <= 1'b0;
    end else if (rx_chip_valid) begin
      rx_half      <= 1'b0;
      rx_hist      <= {rx_hist[SCR_LEN-2:0], rx_d};
      if (dif_en) rx_prev <= rx_c;
      rx_bit       <= rx_b;
      rx_bit_valid <= 1'b1;
      rx_man_err   <= man_en && (rx_first == rx_chip);
    end else begin
      if (!man_en) rx_half <= 1'b0;
      rx_bit_valid <= 1'b0;
      rx_man_err   <= 1'b0;
    end
  end

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> ctrl == $past(cfg_wdata)); // R1
  AST_MAN_SECOND_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pend |=> tx_chip_valid && (tx_chip == !$past(tx_chip))); // R5
  AST_MAN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pend |-> !tx_valid); // R5
  AST_TX_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> tx_chip_valid); // R6
  AST_RX_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_chip_valid && rx_last) |=> rx_bit_valid); // R8
  AST_RX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_chip_valid |=> !rx_bit_valid); // R8
  AST_ERR_WITH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_man_err |-> rx_bit_valid && $past(man_en)); // R9

endmodule

// File: tb/line_codec_tb_top.sv
module line_codec_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_wdata = 4'b0;
  logic tx_bit = 1'b0, tx_valid = 1'b0;
  logic tx_chip, tx_chip_valid;
  logic loop_en = 1'b1;
  logic drv_chip = 1'b0, drv_valid = 1'b0;
  logic rx_chip, rx_chip_valid;
  logic rx_bit, rx_bit_valid, rx_man_err;

  int total = 0, bad = 0;
  bit done = 0;
  string cur_req = "R1";

  bit [3:0] mctrl;
  bit hist[$];
  bit lvl;
  bit exp_chips[$];
  bit exp_bits[$];
  int rx_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rx_chip       = loop_en ? tx_chip : drv_chip;
  assign rx_chip_valid = loop_en ? tx_chip_valid : drv_valid;

  line_codec dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tx_bit(tx_bit), .tx_valid(tx_valid), .tx_chip(tx_chip), .tx_chip_valid(tx_chip_valid),
    .rx_chip(rx_chip), .rx_chip_valid(rx_chip_valid),
    .rx_bit(rx_bit), .rx_bit_valid(rx_bit_valid), .rx_man_err(rx_man_err)
  );

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void model_push(bit b);
    bit s, c;
    s = b ^ mctrl[0];
    if (mctrl[2]) s = s ^ hist[11] ^ hist[16];
    hist.push_front(s);
    void'(hist.pop_back());
    if (mctrl[1]) begin
      lvl = lvl ^ s;
      c = lvl;
    end else c = s;
    exp_chips.push_back(c);
    if (mctrl[3]) exp_chips.push_back(!c);
    exp_bits.push_back(b);
  endfunction

  // per-cycle comparison against the reference model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (tx_chip_valid) begin
        if (exp_chips.size() == 0) check(cur_req, "unexpected chip", 1, 0);
        else check(cur_req, "chip value", tx_chip, exp_chips.pop_front());
      end
      if (loop_en && rx_bit_valid) begin
        rx_seen++;
        if (exp_bits.size() == 0) check("R8", "unexpected rx bit", 1, 0);
        else check("R8", "rx bit value", rx_bit, exp_bits.pop_front());
        check("R9", "no error on clean loop", rx_man_err, 0);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tx_valid = 1'b0;
    drv_valid = 1'b0;
    exp_chips.delete();
    exp_bits.delete();
    hist.delete();
    for (int i = 0; i < 17; i++) hist.push_back(1'b0);
    lvl = 1'b0;
    mctrl = 4'b0010;
    rx_seen = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_ctrl(bit [3:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    mctrl = v;
  endtask

  task automatic send(bit b);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_bit = b;
    model_push(b);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic send_burst(int n, int seed);
    int x = seed;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      x = (x * 1103515245 + 12345) & 32'h7fffffff;
      tx_valid = 1'b1;
      tx_bit = x[16];
      model_push(x[16]);
    end
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic drain(string req, int nbits);
    repeat (4) @(negedge clk);
    check(req, "chips left", exp_chips.size(), 0);
    check(req, "rx bits returned", rx_seen, nbits);
  endtask

  task automatic rx_pair(bit a, bit b);
    @(negedge clk);
    drv_valid = 1'b1; drv_chip = a;
    @(negedge clk);
    drv_chip = b;
    @(negedge clk);
    drv_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    check("R1", "tx_chip_valid after reset", tx_chip_valid, 0);
    check("R1", "rx_bit_valid after reset", rx_bit_valid, 0);
    check("R1", "rx_man_err after reset", rx_man_err, 0);
    // R1/R3: default control is differential only; 1,1,0,1 -> levels 1,0,0,1
    cur_req = "R3";
    @(negedge clk);
    tx_valid = 1'b1; tx_bit = 1'b1; model_push(1'b1);
    @(negedge clk);
    check("R1", "default differential chip", tx_chip, 1);
    check("R6", "one-cycle chip latency", tx_chip_valid, 1);
    tx_bit = 1'b1; model_push(1'b1);
    @(negedge clk);
    check("R3", "level toggles on 1", tx_chip, 0);
    tx_bit = 1'b0; model_push(1'b0);
    @(negedge clk);
    check("R3", "level holds on 0", tx_chip, 0);
    tx_bit = 1'b1; model_push(1'b1);
    @(negedge clk);
    tx_valid = 1'b0;
    check("R3", "level toggles again", tx_chip, 1);
    drain("R3", 4);

    // R2: inversion only
    do_reset();
    cur_req = "R2";
    set_ctrl(4'b0001);
    @(negedge clk);
    tx_valid = 1'b1; tx_bit = 1'b0; model_push(1'b0);
    @(negedge clk);
    tx_valid = 1'b0;
    check("R2", "complemented 0", tx_chip, 1);
    send_burst(20, 7);
    drain("R2", 21);

    // R4: scrambler on periodic all-ones data
    do_reset();
    cur_req = "R4";
    set_ctrl(4'b0100);
    for (int i = 0; i < 40; i++) send(1'b1);
    drain("R4", 40);
    send_burst(30, 99);
    drain("R4", 70);

    // R5: Manchester pairs and their timing
    do_reset();
    cur_req = "R5";
    set_ctrl(4'b1000);
    @(negedge clk);
    tx_valid = 1'b1; tx_bit = 1'b1; model_push(1'b1);
    @(negedge clk);
    tx_valid = 1'b0;
    check("R5", "first half of 1", tx_chip, 1);
    check("R5", "first half valid", tx_chip_valid, 1);
    @(negedge clk);
    check("R5", "second half of 1", tx_chip, 0);
    check("R5", "second half valid", tx_chip_valid, 1);
    tx_valid = 1'b1; tx_bit = 1'b0; model_push(1'b0);
    @(negedge clk);
    tx_valid = 1'b0;
    check("R5", "first half of 0", tx_chip, 0);
    @(negedge clk);
    check("R5", "second half of 0", tx_chip, 1);
    for (int i = 0; i < 12; i++) send(i[0] ^ i[2]);
    drain("R5", 14);

    // R6: no Manchester, back-to-back bits
    do_reset();
    cur_req = "R6";
    set_ctrl(4'b0000);
    send_burst(32, 3);
    drain("R6", 32);

    // R7/R8: all transforms combined, round trip
    do_reset();
    cur_req = "R7";
    set_ctrl(4'b1111);
    for (int i = 0; i < 40; i++) send(i % 3 == 0);
    drain("R7", 40);
    do_reset();
    set_ctrl(4'b0111);
    send_burst(60, 12345);
    drain("R7", 60);
    do_reset();
    cur_req = "R8";
    set_ctrl(4'b1110);
    for (int i = 0; i < 30; i++) send(i[1]);
    drain("R8", 30);
    do_reset();
    set_ctrl(4'b0101);
    send_burst(50, 777);
    drain("R8", 50);

    // R9: Manchester error detection on a driven receive stream
    do_reset();
    cur_req = "R9";
    set_ctrl(4'b1000);
    loop_en = 1'b0;
    rx_pair(1'b1, 1'b1);
    check("R9", "bit valid on bad pair", rx_bit_valid, 1);
    check("R9", "error on equal halves", rx_man_err, 1);
    rx_pair(1'b1, 1'b0);
    check("R9", "bit valid on good pair", rx_bit_valid, 1);
    check("R9", "no error on 1,0", rx_man_err, 0);
    check("R9", "decoded 1,0", rx_bit, 1);
    rx_pair(1'b0, 1'b1);
    check("R9", "decoded 0,1", rx_bit, 0);
    rx_pair(1'b0, 1'b0);
    check("R9", "error on 0,0", rx_man_err, 1);
    @(negedge clk);
    check("R9", "error is a pulse", rx_man_err, 0);
    loop_en = 1'b1;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule